// File: doc/BRIEF.md
# Bit-Serial Add and Decrement Unit

This unit performs 32-bit arithmetic one bit per clock, least-significant bit first. Each cycle it takes one bit of each operand and returns the matching result bit in that same cycle. The result bit is combinational from the current input bits and one stored flip-flop. That flip-flop carries the add carry or the decrement borrow from one bit to the next. The unit can add two operands or subtract one from the first operand, and a mode input selects which.

A `start` strobe marks bit 0 of an operation. In that cycle the unit ignores the stored carry or borrow and uses the seed value for the chosen mode. The mode is captured in the `start` cycle and held until the operation ends. A bit counter marks the result bits with `r_valid` and pulses `done` on the final bit. A new `start` may follow `done` in the next cycle. A `start` that arrives while an operation is still running abandons that operation and begins a new one.

Top module: `bitserial_arith`

## Requirements
- R1: A synchronous reset clears the carry/borrow state, the captured mode, the bit counter and the busy flag. While `rst` is high, and after reset until the next `start`, `r_valid` and `done` are 0. This also holds when reset cuts an operation short.
- R2: With `dec_mode`=0 in the `start` cycle, the result bits presented over W cycles, LSB first, form (X+Y) mod 2^W.
- R3: In add mode the carry into bit 0 is 0, even when the previous operation ended with a carry of 1.
- R4: With `dec_mode`=1 in the `start` cycle, the result bits form (X−1) mod 2^W, and `y_bit` has no effect on any result bit.
- R5: In decrement mode the borrow into bit 0 is 1, whatever state the previous operation left behind.
- R6: `dec_mode` is used only in the `start` cycle. Changing it in later cycles of the same operation does not change the result.
- R7: `r_valid` is 1 in the `start` cycle and in every following cycle up to and including bit W−1. It is 0 outside an operation.
- R8: `done` is a single-cycle pulse in the cycle that presents bit W−1, and in no other cycle.
- R9: A `start` during a running operation restarts the bit count at 0 and reseeds the carry/borrow. The new operation runs a full W bits. This also holds when the `start` falls in the cycle that would have been bit W−1 of the old operation, and in that case no `done` pulse occurs for the old operation.
- R10: A `start` in the cycle right after `done` begins a new operation with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | High only in the bit-0 cycle of an operation |
| dec_mode | input | 1 | Operation select, sampled in the start cycle: 0 = X+Y, 1 = X−1 |
| x_bit | input | 1 | Current bit of operand X |
| y_bit | input | 1 | Current bit of operand Y (unused when decrementing) |
| r_bit | output | 1 | Result bit for the current cycle |
| r_valid | output | 1 | Marks r_bit as part of an operation |
| done | output | 1 | Pulse on the last result bit |

## Verification
Two events can land in one cycle: a new `start`, and bit W−1 of the operation already in flight, which would otherwise carry `done`. The bench creates this overlap by cutting an add short after 31 bits and issuing the next `start` in the following cycle. A second case cuts an operation off after ten bits. In both cases the scoreboard expects bit 0 of the new operation, seeded with a fresh carry or borrow, and no `done` from the abandoned operation. The new operation must then produce its own full 32 bits and end with exactly one `done` pulse. Back-to-back operations, where `start` follows `done` with no gap, are checked the same way. These runs also exercise the carry and borrow seeding across operations.

// File: rtl/bitserial_arith.sv
module bitserial_arith #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic dec_mode,
  input  logic x_bit,
  input  logic y_bit,
  output logic r_bit,
  output logic r_valid,
  output logic done
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          cy_q;
  logic          dec_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  wire          dec_now = start ? dec_mode : dec_q;
  wire          cin     = start ? dec_mode : cy_q;
  wire          yb      = y_bit & ~dec_now;
  wire [CW-1:0] idx     = start ? '0 : cnt_q;
  wire          live    = (start | busy_q) & ~rst;
  wire          is_last = (idx == LAST);

  wire cnext = dec_now ? (~x_bit & cin)
                       : ((x_bit & yb) | (cin & (x_bit ^ yb)));

  assign r_bit   = x_bit ^ yb ^ cin;
  assign r_valid = live;
  assign done    = live & is_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cy_q   <= 1'b0;
      dec_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (live) begin
      cy_q   <= cnext;
      dec_q  <= dec_now;
      busy_q <= ~is_last;
      cnt_q  <= CW'(idx + 1'b1);
    end
  end

  // R3: add seeds carry 0, so bit 0 is x^y
  assert_add_seed_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !dec_mode) |-> (r_bit == (x_bit ^ y_bit)));

  // R5: decrement seeds borrow 1, so bit 0 is ~x
  assert_dec_seed_R5: assert property (@(posedge clk) disable iff (rst)
    (start && dec_mode) |-> (r_bit == ~x_bit));

  // R6: captured mode holds without a start
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(dec_q));

  // R7: valid persists until the last bit
  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !done) |=> r_valid);

  // R7: after the last bit, valid returns only with a start
  assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> (r_valid == start));

  // R8: done never lasts two cycles
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/bitserial_arith_tb.sv
module bitserial_arith_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic dec_mode = 1'b0;
  logic x_bit = 1'b0;
  logic y_bit = 1'b0;
  logic r_bit, r_valid, done;

  typedef struct {
    bit    r;
    bit    d;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  bitserial_arith #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .dec_mode(dec_mode),
    .x_bit(x_bit), .y_bit(y_bit),
    .r_bit(r_bit), .r_valid(r_valid), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pop expected item for every valid result bit
  always @(negedge clk) begin
    if (!finished && r_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R7: r_valid=1 with nothing expected (actual 1, expected 0)");
      end else begin
        item_t e;
        e = q.pop_front();
        if (r_bit !== e.r || done !== e.d) begin
          fails++;
          $display("FAIL %s: r_bit/done actual %b/%b expected %b/%b",
                   e.tag, r_bit, done, e.r, e.d);
        end
      end
    end
  end

  task automatic drive_op(input bit dec, input logic [W-1:0] x,
                          input logic [W-1:0] y, input bit flip,
                          input int nbits, input string tag);
    logic [W-1:0] res;
    res = dec ? x - 1'b1 : x + y;
    for (int i = 0; i < nbits; i++) begin
      item_t e;
      @(posedge clk); #1;
      start    = (i == 0);
      dec_mode = (i == 0) ? dec : (flip ? ~dec : dec);
      x_bit    = x[i];
      y_bit    = dec ? 1'($urandom) : y[i];
      e.r   = res[i];
      e.d   = (i == W - 1);
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic check_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      start = 1'b0;
      dec_mode = 1'($urandom);
      x_bit = 1'($urandom);
      y_bit = 1'($urandom);
      @(negedge clk);
      checks++;
      if (r_valid !== 1'b0 || done !== 1'b0) begin
        fails++;
        $display("FAIL %s: idle r_valid/done actual %b/%b expected 0/0", tag, r_valid, done);
      end
    end
  endtask

  initial begin
    // R1: outputs low during reset
    repeat (2) begin
      @(negedge clk);
      checks++;
      if (r_valid !== 1'b0 || done !== 1'b0) begin
        fails++;
        $display("FAIL R1: reset r_valid/done actual %b/%b expected 0/0", r_valid, done);
      end
    end
    @(posedge clk); #1; rst = 1'b0;
    check_idle(2, "R1");

    drive_op(1'b0, 32'h1234_5678, 32'h0FED_CBA9, 1'b0, W, "R2");
    check_idle(2, "R7");

    // R3 and R10: carry-out op followed with no gap
    drive_op(1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, W, "R2");
    drive_op(1'b0, 32'h0000_0005, 32'h0000_0003, 1'b0, W, "R3");
    drive_op(1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0, W, "R10");
    check_idle(1, "R7");

    // R4: decrement, y randomised
    drive_op(1'b1, 32'h0000_0100, 32'h0, 1'b0, W, "R4");
    drive_op(1'b1, 32'hDEAD_BEEF, 32'h0, 1'b0, W, "R4");
    // R5: decrement after add with final carry 0
    drive_op(1'b0, 32'h0000_0001, 32'h0000_0001, 1'b0, W, "R2");
    drive_op(1'b1, 32'h0000_0000, 32'h0, 1'b0, W, "R5");
    // borrow left at 1, then add must seed 0 (R3)
    drive_op(1'b0, 32'h0000_0007, 32'h0000_0008, 1'b0, W, "R3");
    check_idle(2, "R7");

    // R6: mode toggled after start
    drive_op(1'b1, 32'h0F0F_0000, 32'h0, 1'b1, W, "R6");
    drive_op(1'b0, 32'hAAAA_5555, 32'h5555_AAAB, 1'b1, W, "R6");
    check_idle(1, "R7");

    // R9: abort after 10 bits, then overlap with would-be last bit
    drive_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 10, "R9");
    drive_op(1'b1, 32'h0000_0000, 32'h0, 1'b0, W, "R9");
    drive_op(1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, W - 1, "R9");
    drive_op(1'b0, 32'h0000_0002, 32'h0000_0003, 1'b0, W, "R9");
    check_idle(2, "R7");

    // mixed random ops
    for (int k = 0; k < 20; k++) begin
      bit d;
      d = 1'($urandom);
      drive_op(d, $urandom, $urandom, 1'($urandom), W, d ? "R4" : "R2");
      if (k % 3 == 0) check_idle(1, "R7");
    end
    check_idle(1, "R7");

    // R1: reset mid-operation
    drive_op(1'b0, 32'h1111_1111, 32'h2222_2222, 1'b0, 5, "R1");
    @(posedge clk); #1; start = 1'b0; rst = 1'b1;
    @(negedge clk);
    checks++;
    if (r_valid !== 1'b0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1: in reset r_valid/done actual %b/%b expected 0/0", r_valid, done);
    end
    @(posedge clk); #1; rst = 1'b0;
    check_idle(3, "R1");
    drive_op(1'b1, 32'h0000_0010, 32'h0, 1'b0, W, "R5");
    check_idle(2, "R7");

    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7: leftover expected bits actual %0d expected 0", q.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule